// File: doc/BRIEF.md
# Programmable Bit Clock and Frame Sync Generator

This block makes the bit clock and the frame sync for a serial audio port. The bit clock comes either from an internal divider of the system clock or from an external clock pin, which is brought into the system clock domain through a synchronizer. The frame sync is a pulse counted in bit clocks. Its frame length and its active width are programmed independently, each as a minus-one field. Each output has its own polarity-inversion bit.

Software sets the format through one write strobe. It then starts the port in two steps through a control strobe: first the clock generator alone, then the frame sync with the generator still on. A single control write that clears both enables stops the port and returns both outputs to their inactive levels. A mode bit decides whether the sync is generated here at all. Because the clock source and the sync mode are chosen separately, the port can take its bit clock from an external master and still drive the frame sync itself.

Top module: `frame_sync_gen`

## Requirements
- R1: After reset the generator and the frame sync are off, all configuration bits are zero, and both `bclk_o` and `fsync_o` are 0.
- R2: With the internal source selected (`cfg_ext_clk`=0) and the generator on, the raw bit clock has a period of DIV system clocks. In the cycle the generator turns on, it starts low for DIV/2 cycles and then goes high for DIV/2 cycles.
- R3: With frame sync running, the frame count advances on each rising raw bit clock and returns to 0 after reaching `cfg_frame_period`, so a frame lasts `cfg_frame_period`+1 bit clocks.
- R4: The raw frame sync is active while the frame count is between 0 and `cfg_sync_width` inclusive, which is `cfg_sync_width`+1 bit clocks per frame.
- R5: When `cfg_gen_sync` is 0, no sync is generated and `fsync_o` stays at its inactive level (`cfg_sync_inv`).
- R6: A control write sets the frame sync enable only if the generator was already on before the write and the same write keeps it on. A sync enable written while the generator is off, including in the same write that turns the generator on, has no effect.
- R7: A control write with both enables at 0 stops the port. From the next cycle the raw bit clock and raw sync are 0, so the outputs sit at their inverted-idle levels.
- R8: `bclk_o` is the raw bit clock XOR `cfg_bclk_inv`, and `fsync_o` is the raw sync XOR `cfg_sync_inv`. All four combinations apply.
- R9: With `cfg_ext_clk`=1, the raw bit clock is the external pin after a three-flop synchronizer, gated by the generator enable. The frame count advances on its synchronized rising edges.
- R10: When the frame sync enable goes from 0 to 1, the frame count restarts at 0. The sync is therefore active from the first cycle after the enabling write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_bclk_i | input | 1 | External bit clock pin |
| cfg_we | input | 1 | Format write strobe |
| cfg_sync_width | input | 8 | Active sync length in bit clocks minus one |
| cfg_frame_period | input | 12 | Frame length in bit clocks minus one |
| cfg_gen_sync | input | 1 | 1: sync is generated here |
| cfg_ext_clk | input | 1 | 1: bit clock from the external pin |
| cfg_bclk_inv | input | 1 | Invert the bit clock output |
| cfg_sync_inv | input | 1 | Invert the frame sync output |
| ctl_we | input | 1 | Control write strobe |
| ctl_gen_en | input | 1 | Clock generator enable |
| ctl_sync_en | input | 1 | Frame sync enable |
| bclk_o | output | 1 | Bit clock output |
| fsync_o | output | 1 | Frame sync output |

## Verification
Both outputs are functions of registered state only. A format or control write therefore shows on the outputs in the cycle after the clock edge that takes the strobe, and never combinationally. A level on the external pin reaches `bclk_o` after three rising edges. Frame count steps appear on the same edge where the raw bit clock rises. The bench's behavioural model applies each rising edge's inputs to these latencies and compares both outputs at every falling edge. Targeted checks sample one falling edge after a write.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  localparam int WID_W = 8;
  localparam int PER_W = 12;

  typedef struct packed {
    logic [WID_W-1:0] width;
    logic [PER_W-1:0] period;
    logic             gen_sync;
    logic             ext_sel;
    logic             bclk_inv;
    logic             sync_inv;
  } fmt_t;

  function automatic logic [PER_W-1:0] step_frame(input logic [PER_W-1:0] cnt,
                                                  input logic [PER_W-1:0] per);
    return (cnt >= per) ? '0 : cnt + 1'b1;
  endfunction

  function automatic logic sync_window(input logic [PER_W-1:0] cnt,
                                       input logic [WID_W-1:0] wid);
    return cnt <= PER_W'(wid);
  endfunction
endpackage

// File: rtl/fsg_ctrl.sv
module fsg_ctrl
  import fsg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  fmt_t cfg_in,
  input  logic ctl_we,
  input  logic ctl_gen_en,
  input  logic ctl_sync_en,
  output fmt_t fmt_q,
  output logic gen_en_q,
  output logic sync_en_q,
  output logic sync_start
);
  logic sync_en_d;

  // sync may only be set while the generator is already running and stays on
  assign sync_en_d  = ctl_we ? (ctl_sync_en & ctl_gen_en & gen_en_q) : sync_en_q;
  assign sync_start = sync_en_d & ~sync_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q     <= '0;
      gen_en_q  <= 1'b0;
      sync_en_q <= 1'b0;
    end else begin
      if (cfg_we) fmt_q <= cfg_in;
      if (ctl_we) gen_en_q <= ctl_gen_en;
      sync_en_q <= sync_en_d;
    end
  end
endmodule

// File: rtl/fsg_clk_src.sv
module fsg_clk_src #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gen_en,
  input  logic ext_sel,
  input  logic ext_pin,
  output logic bclk_raw,
  output logic bit_rise
);
  localparam int HALF  = DIV / 2;
  localparam int DIV_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int SYNC_N = 3;

  logic [DIV_W-1:0]  div_cnt;
  logic [SYNC_N-1:0] ext_sh;
  logic              int_level, int_rise, ext_level, ext_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      ext_sh  <= '0;
    end else begin
      ext_sh <= {ext_sh[SYNC_N-2:0], ext_pin};
      if (!gen_en)                            div_cnt <= '0;
      else if (div_cnt == DIV_W'(DIV - 1))    div_cnt <= '0;
      else                                    div_cnt <= div_cnt + 1'b1;
    end
  end

  assign int_level = gen_en & (div_cnt >= DIV_W'(HALF));
  assign int_rise  = gen_en & (div_cnt == DIV_W'(HALF - 1));
  assign ext_level = gen_en & ext_sh[SYNC_N-1];
  assign ext_rise  = gen_en & ext_sh[SYNC_N-2] & ~ext_sh[SYNC_N-1];

  assign bclk_raw = ext_sel ? ext_level : int_level;
  assign bit_rise = ext_sel ? ext_rise  : int_rise;
endmodule

// File: rtl/fsg_frame.sv
module fsg_frame
  import fsg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_en,
  input  logic             sync_start,
  input  logic             bit_rise,
  input  logic             gen_sync,
  input  logic [WID_W-1:0] width,
  input  logic [PER_W-1:0] period,
  output logic [PER_W-1:0] frame_cnt,
  output logic             sync_raw
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          frame_cnt <= '0;
    else if (sync_start) frame_cnt <= '0;
    else if (!sync_en)   frame_cnt <= '0;
    else if (bit_rise)   frame_cnt <= step_frame(frame_cnt, period);
  end

  assign sync_raw = sync_en & gen_sync & sync_window(frame_cnt, width);
endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen
  import fsg_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_bclk_i,
  input  logic             cfg_we,
  input  logic [WID_W-1:0] cfg_sync_width,
  input  logic [PER_W-1:0] cfg_frame_period,
  input  logic             cfg_gen_sync,
  input  logic             cfg_ext_clk,
  input  logic             cfg_bclk_inv,
  input  logic             cfg_sync_inv,
  input  logic             ctl_we,
  input  logic             ctl_gen_en,
  input  logic             ctl_sync_en,
  output logic             bclk_o,
  output logic             fsync_o
);
  fmt_t             cfg_in, fmt_q;
  logic             gen_en_q, sync_en_q, sync_start;
  logic             bclk_raw, bit_rise, sync_raw;
  logic [PER_W-1:0] frame_cnt;

  assign cfg_in = '{width: cfg_sync_width, period: cfg_frame_period,
                    gen_sync: cfg_gen_sync, ext_sel: cfg_ext_clk,
                    bclk_inv: cfg_bclk_inv, sync_inv: cfg_sync_inv};

  fsg_ctrl u_ctrl (
    .clk, .rst_n, .cfg_we, .cfg_in, .ctl_we, .ctl_gen_en, .ctl_sync_en,
    .fmt_q, .gen_en_q, .sync_en_q, .sync_start
  );

  fsg_clk_src #(.DIV(DIV)) u_clk (
    .clk, .rst_n, .gen_en(gen_en_q), .ext_sel(fmt_q.ext_sel),
    .ext_pin(ext_bclk_i), .bclk_raw, .bit_rise
  );

  fsg_frame u_frame (
    .clk, .rst_n, .sync_en(sync_en_q), .sync_start, .bit_rise,
    .gen_sync(fmt_q.gen_sync), .width(fmt_q.width), .period(fmt_q.period),
    .frame_cnt, .sync_raw
  );

  assign bclk_o  = bclk_raw ^ fmt_q.bclk_inv;
  assign fsync_o = sync_raw ^ fmt_q.sync_inv;
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker
  import fsg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic             ctl_we,
  input logic             ctl_gen_en,
  input logic             gen_en_q,
  input logic             sync_en_q,
  input logic             gen_sync,
  input logic             bclk_inv,
  input logic             sync_inv,
  input logic             bclk_raw,
  input logic             bit_rise,
  input logic [PER_W-1:0] frame_cnt,
  input logic             bclk_o,
  input logic             fsync_o
);
  assert_sync_needs_gen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_en_q |-> gen_en_q);

  assert_stop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_gen_en && !cfg_we) |=> (bclk_o == bclk_inv && fsync_o == sync_inv));

  assert_bclk_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en_q |-> !bclk_raw);

  assert_no_sync_mode_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_sync |-> (fsync_o == sync_inv));

  assert_restart_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_en_q) |-> (frame_cnt == '0));

  assert_rise_needs_gen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_rise |-> gen_en_q);
endmodule

bind frame_sync_gen fsg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .ctl_we(ctl_we), .ctl_gen_en(ctl_gen_en),
  .gen_en_q(gen_en_q), .sync_en_q(sync_en_q), .gen_sync(fmt_q.gen_sync),
  .bclk_inv(fmt_q.bclk_inv), .sync_inv(fmt_q.sync_inv), .bclk_raw(bclk_raw),
  .bit_rise(bit_rise), .frame_cnt(frame_cnt), .bclk_o(bclk_o), .fsync_o(fsync_o)
);

// File: tb/frame_sync_gen_test.sv
`timescale 1ns/1ps
module frame_sync_gen_test;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;

  logic clk = 0, rst_n = 0, ext_bclk_i = 0;
  logic cfg_we = 0, cfg_gen_sync = 0, cfg_ext_clk = 0, cfg_bclk_inv = 0, cfg_sync_inv = 0;
  logic [7:0]  cfg_sync_width = 0;
  logic [11:0] cfg_frame_period = 0;
  logic ctl_we = 0, ctl_gen_en = 0, ctl_sync_en = 0;
  logic bclk_o, fsync_o;

  int total = 0, bad = 0;
  string phase = "R1";
  bit ext_run = 0;
  bit done = 0;

  always #5 clk = ~clk;

  frame_sync_gen #(.DIV(DIV)) uut (.*);

  // behavioural reference
  int m_wid, m_per, m_dv, m_fcnt;
  bit m_mode, m_ext, m_ci, m_fi, m_gen, m_fs, m_a, m_b, m_c;
  bit exp_bclk, exp_fs;

  always @(posedge clk) begin
    bit rise, nfs, start;
    if (!rst_n) begin
      m_wid = 0; m_per = 0; m_mode = 0; m_ext = 0; m_ci = 0; m_fi = 0;
      m_gen = 0; m_fs = 0; m_dv = 0; m_fcnt = 0; m_a = 0; m_b = 0; m_c = 0;
    end else begin
      rise  = m_gen && (m_ext ? (m_b && !m_c) : (m_dv == HALF - 1));
      nfs   = ctl_we ? (ctl_sync_en && ctl_gen_en && m_gen) : m_fs;
      start = nfs && !m_fs;
      if (start) m_fcnt = 0;
      else if (!m_fs) m_fcnt = 0;
      else if (rise) m_fcnt = (m_fcnt >= m_per) ? 0 : m_fcnt + 1;
      m_dv = (!m_gen || m_dv == DIV - 1) ? 0 : m_dv + 1;
      m_c = m_b; m_b = m_a; m_a = ext_bclk_i;
      if (cfg_we) begin
        m_wid = cfg_sync_width; m_per = cfg_frame_period; m_mode = cfg_gen_sync;
        m_ext = cfg_ext_clk; m_ci = cfg_bclk_inv; m_fi = cfg_sync_inv;
      end
      if (ctl_we) m_gen = ctl_gen_en;
      m_fs = nfs;
    end
    exp_bclk = (m_gen && (m_ext ? m_c : (m_dv >= HALF))) ^ m_ci;
    exp_fs   = (m_fs && m_mode && (m_fcnt <= m_wid)) ^ m_fi;
  end

  task automatic check(string req, logic act, logic expv, string what);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, expv, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check(phase, bclk_o, exp_bclk, "bclk_o model");
    check(phase, fsync_o, exp_fs, "fsync_o model");
  end

  int ecnt = 0;
  always @(negedge clk) if (ext_run) begin
    ecnt++;
    if (ecnt == 3) begin ecnt = 0; ext_bclk_i <= ~ext_bclk_i; end
  end

  task automatic wr_cfg(int w, int p, bit mode, bit ext, bit ci, bit fi);
    cfg_we = 1; cfg_sync_width = 8'(w); cfg_frame_period = 12'(p);
    cfg_gen_sync = mode; cfg_ext_clk = ext; cfg_bclk_inv = ci; cfg_sync_inv = fi;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic wr_ctl(bit g, bit f);
    ctl_we = 1; ctl_gen_en = g; ctl_sync_en = f;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        done = 1;
      end
      begin
        idle(3); rst_n = 1; @(negedge clk);
        phase = "R1";
        check("R1", bclk_o, 1'b0, "reset bclk_o");
        check("R1", fsync_o, 1'b0, "reset fsync_o");

        wr_cfg(15, 31, 1, 0, 0, 0);
        phase = "R6"; wr_ctl(1, 1); idle(40);
        check("R6", fsync_o, 1'b0, "sync enable with generator off ignored");

        phase = "R10"; wr_ctl(1, 1);
        check("R10", fsync_o, 1'b1, "sync active right after enable");
        phase = "R3"; idle(300);

        phase = "R7"; wr_ctl(0, 0);
        check("R7", bclk_o, 1'b0, "stop bclk idle");
        check("R7", fsync_o, 1'b0, "stop fsync idle");

        phase = "R2"; wr_ctl(1, 0);
        check("R2", bclk_o, 1'b0, "phase 0 low");
        @(negedge clk); check("R2", bclk_o, 1'b0, "phase 1 low");
        @(negedge clk); check("R2", bclk_o, 1'b1, "phase 2 high");
        @(negedge clk); check("R2", bclk_o, 1'b1, "phase 3 high");
        @(negedge clk); check("R2", bclk_o, 1'b0, "wrap low");

        phase = "R4"; wr_cfg(3, 7, 1, 0, 0, 0); wr_ctl(1, 1); idle(100);

        phase = "R8";
        for (int k = 0; k < 4; k++) begin
          wr_cfg(3, 7, 1, 0, k[0], k[1]); idle(40);
        end
        phase = "R7"; wr_ctl(0, 0);
        check("R7", bclk_o, 1'b1, "stop bclk inverted idle");
        check("R7", fsync_o, 1'b1, "stop fsync inverted idle");

        phase = "R5"; wr_cfg(3, 7, 0, 0, 0, 1); wr_ctl(1, 0); wr_ctl(1, 1); idle(60);
        check("R5", fsync_o, 1'b1, "mode off keeps sync inactive");
        wr_ctl(0, 0);

        phase = "R9"; ext_run = 1;
        wr_cfg(1, 3, 1, 1, 0, 0); wr_ctl(1, 0); wr_ctl(1, 1); idle(200);
        wr_ctl(0, 0); ext_run = 0; idle(5);
        done = 1;
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule